// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into a latched interrupt request for a processor, with a mask. The pin is brought into the clock domain by a chain of synchronising flops. A falling edge of the synchronised pin sets a pending latch. A mode bit can also make a held low level keep the request alive. The latch is cleared by reset, by a one-cycle vector-fetch acknowledge strobe from the processor, or by software writing a one to an acknowledge bit.

Software reaches the block through one byte-wide control and status register. The register holds the mode bit and the mask bit, accepts the write-one acknowledge, and shows the pending flag. The mask gates only the request output, so a masked interrupt is still recorded and can be polled. In level mode, an acknowledge that arrives while the pin is still low is held. The latch then releases on the first cycle the synchronised pin reads high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A high-to-low change of `pin_n` is seen by the pending flag after the third rising clock edge that follows it: two synchroniser flops, then the latch.
- R2: Register bit 0 selects the sensitivity: 0 reacts to falling edges only, 1 reacts to falling edges and also to a low level.
- R3: In edge mode (bit 0 = 0) a set latch stays set while no acknowledge or reset occurs, whatever level the pin has.
- R4: In edge mode, a `vec_ack` pulse with no new falling edge in the same cycle clears the latch at that clock edge.
- R5: A register write with bit 2 set is a software acknowledge and acts like `vec_ack`.
- R6: In level mode, an acknowledge given while the synchronised pin is low leaves the latch set. The latch clears on the first cycle the synchronised pin reads high, which is the third rising edge after `pin_n` rises.
- R7: In level mode, a set latch with the pin already high stays set until an acknowledge arrives, and then clears at that clock edge.
- R8: Register bit 1 is the mask. When it is 1, `irq_req` is 0, but the pending flag still sets and reads back. When it is 0, `irq_req` equals the pending flag.
- R9: When a falling edge and an acknowledge fall in the same cycle, the latch ends set.
- R10: The read value has the pending flag in bit 3 and bit 2 always 0. It has the mask in bit 1, the mode in bit 0, and zeros above bit 3.
- R11: Reset (`rst_n` low, asynchronous) clears the latch, the mask and the mode. The read value is then 0x00 and `irq_req` is 0.
- R12: Selecting level mode while the synchronised pin is already low, with the latch clear, sets the latch on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe, one cycle |
| reg_wr_en | input | 1 | Register write enable |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| irq_req | output | 1 | Masked interrupt request to the processor |

## Verification
The assertions assume that `vec_ack` and register writes are single-cycle, synchronous strobes. They also assume that the pin's only route into the latch is through the synchroniser, so a single falling edge shows up as exactly one cycle of the edge signal. The stimulus changes `pin_n` only on falling clock edges. It holds each pin level for at least three cycles before it depends on that level, and it places acknowledges at chosen cycles relative to pin transitions, including one that coincides with a new edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned BIT_MODE = 0;
    localparam int unsigned BIT_MASK = 1;
    localparam int unsigned BIT_ACK  = 2;
    localparam int unsigned BIT_PEND = 3;

    typedef struct packed {
        logic mask;
        logic mode;
    } ctl_t;

    typedef struct packed {
        logic pend;
        logic ack_seen;
    } latch_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_lo,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_n};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign pin_lo = ~st_q.sh[STAGES-1];
    assign fall   = st_q.prev & ~st_q.sh[STAGES-1];

    // A detected edge lasts one cycle only (supports R1)
    p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             pend,
    output logic             mode,
    output logic             mask,
    output logic             sw_ack,
    output logic [REG_W-1:0] rdata
);
    ctl_t ctl_d, ctl_q;
    logic unused_hi;

    assign unused_hi = ^wdata[REG_W-1:BIT_PEND];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.mode = wdata[BIT_MODE];
            ctl_d.mask = wdata[BIT_MASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sw_ack = wr_en & wdata[BIT_ACK];
    assign mode   = ctl_q.mode;
    assign mask   = ctl_q.mask;

    always_comb begin
        rdata           = '0;
        rdata[BIT_MODE] = ctl_q.mode;
        rdata[BIT_MASK] = ctl_q.mask;
        rdata[BIT_PEND] = pend;
    end

    // R10: a write updates the control bits seen on the read port
    p_write_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[BIT_MODE] == $past(wdata[BIT_MODE])) &&
                  (rdata[BIT_MASK] == $past(wdata[BIT_MASK])));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic pin_lo,
    input  logic fall,
    input  logic ack,
    output logic pend
);
    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall) begin
            st_d.pend     = 1'b1;
            st_d.ack_seen = 1'b0;
        end else if (mode) begin
            if (st_q.pend) begin
                if (ack || st_q.ack_seen) begin
                    if (!pin_lo) begin
                        st_d.pend     = 1'b0;
                        st_d.ack_seen = 1'b0;
                    end else begin
                        st_d.ack_seen = 1'b1;
                    end
                end
            end else if (pin_lo) begin
                st_d.pend     = 1'b1;
                st_d.ack_seen = 1'b0;
            end
        end else begin
            if (ack) st_d.pend = 1'b0;
            st_d.ack_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && ack) |=> pend);

    p_edge_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && ack && !fall) |=> !pend);

    p_edge_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && pend && !ack) |=> pend);

    p_level_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && pend && pin_lo) |=> pend);

    p_level_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && pend && (ack || st_q.ack_seen) && !pin_lo && !fall) |=> !pend);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_n,
    input  logic             vec_ack,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req
);
    logic pin_lo, fall, mode, mask, sw_ack, pend;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (pin_n),
        .pin_lo(pin_lo),
        .fall  (fall)
    );

    irq_ctl_reg #(.REG_W(REG_W)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .pend  (pend),
        .mode  (mode),
        .mask  (mask),
        .sw_ack(sw_ack),
        .rdata (reg_rdata)
    );

    irq_req_latch latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .pin_lo(pin_lo),
        .fall  (fall),
        .ack   (vec_ack | sw_ack),
        .pend  (pend)
    );

    assign irq_req = pend & ~mask;

    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BIT_MASK] |-> !irq_req);

    p_sw_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[BIT_ACK] && !mode && !fall) |=> !pend);
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module ext_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       vec_ack = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       irq;
    } item_t;

    item_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .vec_ack(vec_ack),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    // Monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1.5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (reg_rdata !== it.rd || irq_req !== it.irq) begin
                    bad++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, reg_rdata, irq_req, it.rd, it.irq);
                end
            end
        end
    end

    // Push an expectation for the state after the next rising edge
    task automatic expect_next(input string tag, input logic [7:0] rd, input logic irq);
        item_t it;
        it.tag = tag; it.rd = rd; it.irq = irq;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vack_exp(input string tag, input logic [7:0] rd, input logic irq);
        vec_ack = 1'b1;
        expect_next(tag, rd, irq);
        vec_ack = 1'b0;
    endtask

    task automatic wr_exp(input logic [7:0] d, input string tag,
                          input logic [7:0] rd, input logic irq);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        expect_next(tag, rd, irq);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_next("R11 R10 reset state", 8'h00, 1'b0);

        // R1: edge reaches pending flag at third edge
        pin_n = 1'b0;
        expect_next("R1 not yet (1)", 8'h00, 1'b0);
        expect_next("R1 not yet (2)", 8'h00, 1'b0);
        expect_next("R1 set", 8'h08, 1'b1);
        // R3: held low in edge mode, still set
        expect_next("R3 held low", 8'h08, 1'b1);
        pin_n = 1'b1;
        tick(3);
        expect_next("R3 pin high", 8'h08, 1'b1);
        // R4
        vack_exp("R4 vector ack clears", 8'h00, 1'b0);

        // R5 software ack
        pin_n = 1'b0;
        tick(2);
        expect_next("R5 set before ack", 8'h08, 1'b1);
        wr_exp(8'h04, "R5 sw ack clears", 8'h00, 1'b0);
        pin_n = 1'b1;
        tick(3);

        // R10 layout
        wr_exp(8'hFF, "R10 read layout", 8'h03, 1'b0);
        wr_exp(8'h00, "R10 clear ctl", 8'h00, 1'b0);

        // R8 mask
        wr_exp(8'h02, "R8 mask on", 8'h02, 1'b0);
        pin_n = 1'b0;
        expect_next("R8 wait (1)", 8'h02, 1'b0);
        expect_next("R8 wait (2)", 8'h02, 1'b0);
        expect_next("R8 pending masked", 8'h0A, 1'b0);
        wr_exp(8'h00, "R8 unmask", 8'h08, 1'b1);
        vack_exp("R8 R4 clear", 8'h00, 1'b0);
        pin_n = 1'b1;
        tick(3);

        // R6 / R2 level mode, ack while low
        wr_exp(8'h01, "R2 level mode", 8'h01, 1'b0);
        pin_n = 1'b0;
        expect_next("R6 wait (1)", 8'h01, 1'b0);
        expect_next("R6 wait (2)", 8'h01, 1'b0);
        expect_next("R6 set", 8'h09, 1'b1);
        vack_exp("R6 ack while low keeps", 8'h09, 1'b1);
        expect_next("R6 still held", 8'h09, 1'b1);
        pin_n = 1'b1;
        expect_next("R6 rise (1)", 8'h09, 1'b1);
        expect_next("R6 rise (2)", 8'h09, 1'b1);
        expect_next("R6 released", 8'h01, 1'b0);

        // R7 level mode, ack with pin high
        pin_n = 1'b0;
        expect_next("R7 wait (1)", 8'h01, 1'b0);
        expect_next("R7 wait (2)", 8'h01, 1'b0);
        expect_next("R7 set", 8'h09, 1'b1);
        pin_n = 1'b1;
        tick(3);
        expect_next("R7 held without ack", 8'h09, 1'b1);
        vack_exp("R7 ack clears", 8'h01, 1'b0);

        // R6 with software ack
        pin_n = 1'b0;
        expect_next("R6 sw wait (1)", 8'h01, 1'b0);
        expect_next("R6 sw wait (2)", 8'h01, 1'b0);
        expect_next("R6 sw set", 8'h09, 1'b1);
        wr_exp(8'h05, "R6 R5 sw ack while low", 8'h09, 1'b1);
        pin_n = 1'b1;
        expect_next("R6 sw rise (1)", 8'h09, 1'b1);
        expect_next("R6 sw rise (2)", 8'h09, 1'b1);
        expect_next("R6 sw released", 8'h01, 1'b0);

        // R9 set wins
        wr_exp(8'h00, "R2 edge mode", 8'h00, 1'b0);
        pin_n = 1'b0;
        expect_next("R9 wait (1)", 8'h00, 1'b0);
        expect_next("R9 wait (2)", 8'h00, 1'b0);
        expect_next("R9 first set", 8'h08, 1'b1);
        pin_n = 1'b1;
        tick(3);
        expect_next("R3 high still set", 8'h08, 1'b1);
        pin_n = 1'b0;
        expect_next("R9 edge (1)", 8'h08, 1'b1);
        expect_next("R9 edge (2)", 8'h08, 1'b1);
        vack_exp("R9 edge and ack together", 8'h08, 1'b1);
        vack_exp("R4 ack pin low edge mode", 8'h00, 1'b0);

        // R12 level mode while low
        wr_exp(8'h01, "R12 select level", 8'h01, 1'b0);
        expect_next("R12 level sets", 8'h09, 1'b1);

        // R11 reset mid-run
        wr_exp(8'h03, "R8 mask over level", 8'h0B, 1'b0);
        pin_n = 1'b1;
        rst_n = 1'b0;
        expect_next("R11 reset clears", 8'h00, 1'b0);
        tick(2);
        rst_n = 1'b1;
        expect_next("R11 after release", 8'h00, 1'b0);

        tick(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule